// File: doc/BRIEF.md
# Two-Phase Memory Bus Sequencer

This block sequences one shared external memory bus for a very small processor core. Each bus access occupies two clocks. In the first clock the address, chip selects and write data settle. In the second clock the memory or the core latches. One fetched word carries two instruction slots, and the low half runs first. Each instruction makes one load access and one store access. The ALU step fits in the boundary between those two accesses. A word therefore costs one two-clock fetch plus two four-clock instructions: ten clocks per word, or five clocks per instruction.

Decoding and arithmetic are left to a small combinational stub outside the block. The sequencer presents the current instruction slot and the latched load value. The stub returns the load address, the store address and the ALU result. A WAIT input lets a slow memory hold the sequencer. It is looked at only in the latch clock of an access. An access that has begun always runs to its end before the bus goes idle.

Top module: `membus_seq`

## Requirements
- R1: While reset is held, the bus presents a fetch settle clock at address 0: busOe=1, busWe=0, busCs=00, instrDone=0. The first clock after reset is that fetch.
- R2: Every access lasts exactly two clocks, a settle clock then a latch clock. Address, chip selects, output enable and write data are identical in both clocks.
- R3: A fetch drives busAddr = program counter, busOe=1 and busCs=00 (busCs[0]=0 means program memory). The word read in its latch clock supplies slot 0 from bits [7:0] and slot 1 from bits [15:8], executed in that order.
- R4: A load drives busAddr = loadAddr and busOe=1. It sets busCs[0]=1 for data memory and busCs[1] = bit 7 of the current slot, the stack select. The read data captured in its latch clock appears on aluOperand and holds until the next load.
- R5: A store drives busAddr = storeAddr with the same chip selects as its load and busOe=0. busWe=1 only in its latch clock. busDout equals aluResult, unchanged across both clocks, and busDout is 0 outside stores.
- R6: With WAIT low, a word takes ten clocks. instrDone is high for exactly the latch clock of each store. Counting the first clock after reset as cycle 0, instrDone is high in cycles 5, 9, 15 and 19.
- R7: The program counter advances by one after the store of slot 1, and a fetch follows at once. No fetch occurs between the two slots of one word.
- R8: WAIT high in a latch clock inserts hold clocks after that access. There is one hold clock for each consecutive clock that WAIT stays high. During a hold, busAddr, busDout, busOe, busWe and busCs are all 0.
- R9: WAIT high only in a settle clock has no effect. The access finishes and the next one starts without any hold clock.
- R10: When a hold ends, the access that was due next starts with its settle clock. No access is repeated or skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| waitIn | input | 1 | Hold request, looked at in latch clocks |
| busRdata | input | DATA_W | Read data from the memory bus |
| loadAddr | input | ADDR_W | Load address for the current slot, from the stub |
| storeAddr | input | ADDR_W | Store address for the current slot, from the stub |
| aluResult | input | DATA_W | ALU result from the stub |
| busAddr | output | ADDR_W | Bus address |
| busDout | output | DATA_W | Bus write data |
| busOe | output | 1 | Output enable for fetches and loads |
| busWe | output | 1 | Write strobe |
| busCs | output | 2 | Chip selects: bit 0 data/program, bit 1 stack |
| curInstr | output | DATA_W/SLOTS | Instruction slot now executing |
| aluOperand | output | DATA_W | Value captured by the latest load |
| instrDone | output | 1 | One-clock completion pulse per instruction |

## Verification
The bench drives WAIT high exactly in a store's latch clock. A design that samples WAIT in any clock, or that cuts an access short, would show hold clocks in the wrong place or a half access. It also raises WAIT only in a settle clock, where a design that stalls there would insert idle clocks. The scoreboard compares every active bus clock against the expected access order over several words. It would catch slot order swapped, a refetch between slots, a repeated or dropped access after a hold, a write strobe in the settle clock, wrong stack selects, and store data that moves between its two clocks. The first completion pulses are timed against fixed cycle numbers to pin the ten-clock word.

// File: rtl/membus_seq_pkg.sv
package membus_seq_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_IDLE  = 2'd3
  } accKind_e;

  // Control-to-datapath strobes for the current clock.
  typedef struct packed {
    accKind_e kind;       // access on the bus this clock
    logic     latchPh;    // 0: settle clock, 1: latch clock
    logic     fetchLatch; // capture instruction word
    logic     loadLatch;  // capture load data
    logic     pcStep;     // last slot stored, advance program counter
  } seqStrobe_t;

endpackage

// File: rtl/membus_seq_ctrl.sv
module membus_seq_ctrl
  import membus_seq_pkg::*;
#(
  parameter int SLOTS = 2,
  localparam int SIW  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           waitIn,
  output seqStrobe_t     strobe,
  output logic [SIW-1:0] slotIdx,
  output logic           instrDone
);

  localparam logic [SIW-1:0] LAST_SLOT = SIW'(SLOTS - 1);

  accKind_e       kindQ, pendKindQ, nxtKind;
  logic           latchQ;
  logic [SIW-1:0] slotQ, pendSlotQ, nxtSlot;

  // Access that follows the one now on the bus.
  always_comb begin
    nxtKind = pendKindQ;
    nxtSlot = pendSlotQ;
    case (kindQ)
      ACC_FETCH: begin
        nxtKind = ACC_LOAD;
        nxtSlot = '0;
      end
      ACC_LOAD: begin
        nxtKind = ACC_STORE;
        nxtSlot = slotQ;
      end
      ACC_STORE: begin
        if (slotQ == LAST_SLOT) begin
          nxtKind = ACC_FETCH;
          nxtSlot = '0;
        end else begin
          nxtKind = ACC_LOAD;
          nxtSlot = slotQ + 1'b1;
        end
      end
      default: begin
        nxtKind = pendKindQ;
        nxtSlot = pendSlotQ;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kindQ     <= ACC_FETCH;
      latchQ    <= 1'b0;
      slotQ     <= '0;
      pendKindQ <= ACC_FETCH;
      pendSlotQ <= '0;
    end else if (kindQ == ACC_IDLE) begin
      if (!waitIn) begin
        kindQ  <= pendKindQ;
        slotQ  <= pendSlotQ;
        latchQ <= 1'b0;
      end
    end else if (!latchQ) begin
      latchQ <= 1'b1;
    end else if (waitIn) begin
      kindQ     <= ACC_IDLE;
      latchQ    <= 1'b0;
      pendKindQ <= nxtKind;
      pendSlotQ <= nxtSlot;
    end else begin
      kindQ  <= nxtKind;
      slotQ  <= nxtSlot;
      latchQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.kind       = kindQ;
    strobe.latchPh    = latchQ;
    strobe.fetchLatch = (kindQ == ACC_FETCH) && latchQ;
    strobe.loadLatch  = (kindQ == ACC_LOAD) && latchQ;
    strobe.pcStep     = (kindQ == ACC_STORE) && latchQ && (slotQ == LAST_SLOT);
  end

  assign slotIdx   = slotQ;
  assign instrDone = (kindQ == ACC_STORE) && latchQ;

  AST_SETTLE_THEN_LATCH: assert property (@(posedge clk) disable iff (rst)
    (!latchQ && kindQ != ACC_IDLE) |=> (latchQ && kindQ == $past(kindQ))); // R2
  AST_SETTLE_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!latchQ && kindQ != ACC_IDLE && waitIn) |=> (kindQ != ACC_IDLE)); // R9
  AST_LATCH_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (latchQ && kindQ != ACC_IDLE && waitIn) |=> (kindQ == ACC_IDLE)); // R8
  AST_HOLD_RESUMES: assert property (@(posedge clk) disable iff (rst)
    (kindQ == ACC_IDLE && !waitIn) |=> (kindQ != ACC_IDLE && !latchQ)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    instrDone |=> !instrDone); // R6

endmodule

// File: rtl/membus_seq_dp.sv
module membus_seq_dp
  import membus_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SLOTS  = 2,
  localparam int SIW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int SLOT_W = DATA_W / SLOTS
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [SIW-1:0]    slotIdx,
  input  logic [DATA_W-1:0] busRdata,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic [DATA_W-1:0] aluResult,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic              busOe,
  output logic              busWe,
  output logic [1:0]        busCs,
  output logic [SLOT_W-1:0] curInstr,
  output logic [DATA_W-1:0] aluOperand
);

  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] instrWord;
  logic [DATA_W-1:0] operandQ;
  logic [SLOT_W-1:0] slotArr [SLOTS];
  logic              stackSel;

  // Slot g occupies the g-th SLOT_W-bit field, lowest first.
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slotArr[g] = instrWord[g*SLOT_W +: SLOT_W];
  end

  assign curInstr = slotArr[slotIdx];
  assign stackSel = curInstr[SLOT_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      instrWord <= '0;
      operandQ  <= '0;
    end else begin
      if (strobe.pcStep)     pc        <= pc + 1'b1;
      if (strobe.fetchLatch) instrWord <= busRdata;
      if (strobe.loadLatch)  operandQ  <= busRdata;
    end
  end

  assign aluOperand = operandQ;

  always_comb begin
    busAddr = '0;
    busDout = '0;
    busOe   = 1'b0;
    busWe   = 1'b0;
    busCs   = 2'b00;
    case (strobe.kind)
      ACC_FETCH: begin
        busAddr = pc;
        busOe   = 1'b1;
      end
      ACC_LOAD: begin
        busAddr = loadAddr;
        busOe   = 1'b1;
        busCs   = {stackSel, 1'b1};
      end
      ACC_STORE: begin
        busAddr = storeAddr;
        busDout = aluResult;
        busWe   = strobe.latchPh;
        busCs   = {stackSel, 1'b1};
      end
      default: ;
    endcase
  end

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busOe && busWe)); // R5
  AST_STORE_STABLE: assert property (@(posedge clk) disable iff (rst)
    busWe |-> ($stable(busDout) && $stable(busAddr) && $stable(busCs))); // R5
  AST_WE_IN_DATA: assert property (@(posedge clk) disable iff (rst)
    busWe |-> busCs[0]); // R5
  AST_FETCH_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (rst)
    strobe.pcStep |=> ((busOe && busCs == 2'b00) || (!busOe && busCs == 2'b00))); // R7

endmodule

// File: rtl/membus_seq.sv
module membus_seq
  import membus_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SLOTS  = 2,
  localparam int SIW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int SLOT_W = DATA_W / SLOTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              waitIn,
  input  logic [DATA_W-1:0] busRdata,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic [DATA_W-1:0] aluResult,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic              busOe,
  output logic              busWe,
  output logic [1:0]        busCs,
  output logic [SLOT_W-1:0] curInstr,
  output logic [DATA_W-1:0] aluOperand,
  output logic              instrDone
);

  seqStrobe_t     strobe;
  logic [SIW-1:0] slotIdx;

  membus_seq_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .waitIn    (waitIn),
    .strobe    (strobe),
    .slotIdx   (slotIdx),
    .instrDone (instrDone)
  );

  membus_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .slotIdx    (slotIdx),
    .busRdata   (busRdata),
    .loadAddr   (loadAddr),
    .storeAddr  (storeAddr),
    .aluResult  (aluResult),
    .busAddr    (busAddr),
    .busDout    (busDout),
    .busOe      (busOe),
    .busWe      (busWe),
    .busCs      (busCs),
    .curInstr   (curInstr),
    .aluOperand (aluOperand)
  );

endmodule

// File: tb/membus_seq_test.sv
module membus_seq_test;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  addr;
    logic [1:0]  cs;
    logic        oe;
    logic        we;
    logic [15:0] dout;
  } busItem_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        waitIn = 1'b0;
  logic [15:0] busRdata, aluResult, busDout, aluOperand;
  logic [7:0]  loadAddr, storeAddr, busAddr, curInstr;
  logic        busOe, busWe, instrDone;
  logic [1:0]  busCs;

  busItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int doneCount = 0;
  int doneCyc[4];
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  membus_seq uut (
    .clk(clk), .rst(rst), .waitIn(waitIn), .busRdata(busRdata),
    .loadAddr(loadAddr), .storeAddr(storeAddr), .aluResult(aluResult),
    .busAddr(busAddr), .busDout(busDout), .busOe(busOe), .busWe(busWe),
    .busCs(busCs), .curInstr(curInstr), .aluOperand(aluOperand),
    .instrDone(instrDone)
  );

  function automatic logic [15:0] progWord(input logic [7:0] a);
    logic [7:0] p5, p3;
    p5 = a * 8'd5 + 8'd2;
    p3 = a * 8'd3 + 8'd1;
    return {a[0], p5[6:0], a[1], p3[6:0]};
  endfunction

  function automatic logic [15:0] dataVal(input logic [7:0] a);
    return ({8'h00, a} * 16'h0123) ^ 16'hA5C3;
  endfunction

  // Stub datapath and memory models
  assign loadAddr  = {1'b0, curInstr[6:0]};
  assign storeAddr = {1'b1, curInstr[6:0]};
  assign aluResult = aluOperand + 16'h0101;
  assign busRdata  = !busOe ? 16'h0000 : (busCs[0] ? dataVal(busAddr) : progWord(busAddr));

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  // Driver: expected bus clocks for one word
  task automatic pushWord(input logic [7:0] pc);
    logic [15:0] w;
    w = progWord(pc);
    repeat (2) expQ.push_back('{addr: pc, cs: 2'b00, oe: 1'b1, we: 1'b0, dout: 16'h0});
    for (int s = 0; s < 2; s++) begin
      logic [7:0]  ins, la, sa;
      logic [15:0] v;
      ins = (s == 0) ? w[7:0] : w[15:8];
      la  = {1'b0, ins[6:0]};
      sa  = {1'b1, ins[6:0]};
      v   = dataVal(la) + 16'h0101;
      repeat (2) expQ.push_back('{addr: la, cs: {ins[7], 1'b1}, oe: 1'b1, we: 1'b0, dout: 16'h0});
      expQ.push_back('{addr: sa, cs: {ins[7], 1'b1}, oe: 1'b0, we: 1'b0, dout: v});
      expQ.push_back('{addr: sa, cs: {ins[7], 1'b1}, oe: 1'b0, we: 1'b1, dout: v});
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Monitor: pops expected items as active bus clocks appear
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && !ended) begin
        if (busOe || busWe || busCs[0]) begin
          busItem_t got, exp;
          string tag;
          got = '{addr: busAddr, cs: busCs, oe: busOe, we: busWe, dout: busDout};
          if (expQ.size() == 0) begin
            check(1'b0, $sformatf("R10 unexpected access at cycle %0d: got %h expected none", cyc, got));
          end else begin
            exp = expQ.pop_front();
            tag = !exp.cs[0] ? "R2 R3 R7 fetch" : (exp.oe ? "R2 R4 load" : "R2 R5 store");
            check(got == exp, $sformatf("%s at cycle %0d: got %h expected %h", tag, cyc, got, exp));
          end
        end
        if (busWe || instrDone)
          check(busWe && instrDone, $sformatf("R6 done pulse at cycle %0d: got done=%b expected %b", cyc, instrDone, busWe));
        if (instrDone) begin
          if (doneCount < 4) doneCyc[doneCount] = cyc;
          doneCount++;
        end
        cyc++;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired: got no end, expected finish");
    finishRun();
  end

  initial begin
    for (int p = 0; p < 12; p++) pushWord(8'(p));
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(busAddr == 8'h00 && busOe && !busWe && busCs == 2'b00 && !instrDone,
          $sformatf("R1 reset state: got addr=%h oe=%b we=%b cs=%b done=%b expected 00 1 0 00 0",
                    busAddr, busOe, busWe, busCs, instrDone));
    @(posedge clk);
    #1 rst = 1'b0;

    // R6: cadence of the first completions without WAIT
    while (doneCount < 4) @(negedge clk);
    begin
      int expCyc[4] = '{5, 9, 15, 19};
      for (int k = 0; k < 4; k++)
        check(doneCyc[k] == expCyc[k],
              $sformatf("R6 completion %0d: got cycle %0d expected %0d", k, doneCyc[k], expCyc[k]));
    end

    // R8/R10: WAIT high in a store latch clock for three clocks
    do @(negedge clk); while (!instrDone);
    waitIn = 1'b1;
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      check(!busOe && !busWe && busCs == 2'b00 && busDout == 16'h0 && busAddr == 8'h00,
            $sformatf("R8 hold clock %0d: got oe=%b we=%b cs=%b dout=%h addr=%h expected all zero",
                      h, busOe, busWe, busCs, busDout, busAddr));
      if (h == 2) waitIn = 1'b0;
    end
    @(negedge clk);
    check(busOe || busCs[0], $sformatf("R10 resume: got oe=%b cs=%b expected an active access", busOe, busCs));

    // R9: WAIT high only in a settle clock
    do @(negedge clk); while (!instrDone);
    @(negedge clk);
    waitIn = 1'b1;
    @(negedge clk);
    waitIn = 1'b0;
    check(busOe || busCs[0], $sformatf("R9 latch after settle wait: got oe=%b cs=%b expected active", busOe, busCs));
    @(negedge clk);
    check(busOe || busCs[0], $sformatf("R9 next settle: got oe=%b cs=%b expected active", busOe, busCs));

    while (doneCount < 18) @(negedge clk);
    finishRun();
  end

endmodule